// File: doc/BRIEF.md
# Sliding-Window Bit/Sample Cross-Correlator

This block keeps a running cross-correlation between a set of antipodal training bits and a vector of received chip samples. It stores a matrix with one row per training bit and one column per chip sample. Each entry is a 16-bit signed accumulator.

On every accepted update the block adds the contribution of the bits entering the window to each entry. In the same cycle it removes the contribution of the bits leaving the window. The window therefore slides by one bit period per update. Because a training bit is worth only +1 or -1, no multiplier is used. Each product is formed by passing the sample through unchanged or negated, as the bit selects.

Only the real (in-phase) part of the received signal is processed. The window storage that supplies the leaving bits and leaving samples sits outside this block. A downstream estimator reads the entries one at a time through a combinational indexed read port.

Top module: `sliding_xcorr`

## Requirements
- R1: After a cycle with `rst_n` low at a rising edge, every entry reads zero.
- R2: With `clr_i` high at a rising edge, every entry becomes zero. This holds even when `valid_i` is high in the same cycle.
- R3: With `valid_i` low and `clr_i` low, no entry changes, whatever the bit and sample inputs hold.
- R4: Entering term for entry (r, c): if bit r of `new_bits_i` is 1, sample c of `new_samp_i` is added. If that bit is 0, the sample is subtracted. Sample c occupies bits [8c+7:8c] as an 8-bit two's complement value.
- R5: Leaving term for entry (r, c): if bit r of `old_bits_i` is 1, sample c of `old_samp_i` is subtracted. If that bit is 0, the sample is added. The sample uses the same lane layout as in R4.
- R6: When both terms are present, they are applied together in one update. The result is the previous value plus the entering term plus the leaving term.
- R7: A result above +32767 is held at +32767.
- R8: A result below -32768 is held at -32768.
- R9: `rd_data_o` shows the entry selected by `rd_row_i` and `rd_col_i` in the same cycle, with no clock edge needed. An index outside the matrix reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all entries; overrides `valid_i` |
| valid_i | input | 1 | Apply one window slide this cycle |
| new_bits_i | input | ROWS | Bits entering the window, one per row (1 = +1, 0 = -1) |
| old_bits_i | input | ROWS | Bits leaving the window, one per row |
| new_samp_i | input | CHIPS*8 | Entering received samples, signed, lane c at [8c+7:8c] |
| old_samp_i | input | CHIPS*8 | Leaving received samples, same layout |
| rd_row_i | input | ROW_IW | Row index for the read port |
| rd_col_i | input | COL_IW | Column index for the read port |
| rd_data_o | output | 16 | Selected accumulator, two's complement |

## Verification
The bench drives a series of patterns and compares every entry with a behavioural model after each cycle:
- Random entering bits and samples with the leaving samples held at zero. This isolates the add/subtract choice for the entering term.
- The mirror case, with the entering samples held at zero. This isolates the inverted rule for the leaving term.
- Fully random traffic on both terms. This shows that the two terms are summed within one update, and that the read port addresses the right row and column lane.
- Long runs of same-sign steps that drive every entry into the positive rail and then the negative rail. These show clamping in place of wrap-around.
- Cycles with `valid_i` low while the data inputs toggle, and a clear raised together with `valid_i`. These show that idle cycles hold the entries and that the clear takes priority.

// File: rtl/xcorr_pkg.sv
// Package: shared widths for the sliding cross-correlator.
// Assumes samples are two's complement and accumulators are signed.
package xcorr_pkg;
    localparam int SAMP_W = 8;
    localparam int ACC_W  = 16;
endpackage

// File: rtl/xcorr_sign_term.sv
// Module: xcorr_sign_term
// Forms bit*sample for an antipodal bit without a multiplier: the sample
// passes through or is negated. ADD_ON_ONE picks which bit value adds.
// Assumes SAMP_W-bit two's complement input; output is one bit wider so
// negating the most negative sample cannot overflow.
module xcorr_sign_term #(
    parameter int SAMP_W     = xcorr_pkg::SAMP_W,
    parameter bit ADD_ON_ONE = 1'b1
) (
    input  logic                     bit_i,
    input  logic signed [SAMP_W-1:0] samp_i,
    output logic signed [SAMP_W:0]   term_o
);
    logic signed [SAMP_W:0] samp_ext;

    // Sign-extend, then pass or negate depending on the bit.
    always_comb begin
        samp_ext = {samp_i[SAMP_W-1], samp_i};
        term_o   = (bit_i == ADD_ON_ONE) ? samp_ext : -samp_ext;
    end
endmodule

// File: rtl/xcorr_cell.sv
// Module: xcorr_cell
// One matrix entry: adds the entering term and the leaving term in the
// same update and clamps to the signed accumulator range.
// Assumes clear outranks valid and reset is synchronous, active low.
module xcorr_cell #(
    parameter int SAMP_W = xcorr_pkg::SAMP_W,
    parameter int ACC_W  = xcorr_pkg::ACC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     valid_i,
    input  logic                     new_bit_i,
    input  logic                     old_bit_i,
    input  logic signed [SAMP_W-1:0] new_samp_i,
    input  logic signed [SAMP_W-1:0] old_samp_i,
    output logic signed [ACC_W-1:0]  acc_o
);
    localparam int TERM_W  = SAMP_W + 1;
    localparam int DELTA_W = SAMP_W + 2;
    localparam int SUM_W   = ACC_W + 1;
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [TERM_W-1:0]  enter_term;
    logic signed [TERM_W-1:0]  leave_term;
    logic signed [DELTA_W-1:0] delta;
    logic signed [SUM_W-1:0]   sum_wide;
    logic signed [ACC_W-1:0]   acc_next;

    // Entering bit: 1 adds the sample.
    xcorr_sign_term #(.SAMP_W(SAMP_W), .ADD_ON_ONE(1'b1)) u_enter (
        .bit_i  (new_bit_i),
        .samp_i (new_samp_i),
        .term_o (enter_term)
    );

    // Leaving bit: 1 subtracts the sample.
    xcorr_sign_term #(.SAMP_W(SAMP_W), .ADD_ON_ONE(1'b0)) u_leave (
        .bit_i  (old_bit_i),
        .samp_i (old_samp_i),
        .term_o (leave_term)
    );

    // Combine both terms, add to the entry and clamp to the rails.
    always_comb begin
        delta    = DELTA_W'(enter_term) + DELTA_W'(leave_term);
        sum_wide = SUM_W'(acc_o) + SUM_W'(delta);
        if (sum_wide > SUM_W'(ACC_MAX)) begin
            acc_next = ACC_MAX;
        end else if (sum_wide < SUM_W'(ACC_MIN)) begin
            acc_next = ACC_MIN;
        end else begin
            acc_next = sum_wide[ACC_W-1:0];
        end
    end

    // Accumulator register: reset/clear to zero, update on valid.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            acc_o <= '0;
        end else if (valid_i) begin
            acc_o <= acc_next;
        end
    end

    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_o == '0));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !valid_i) |=> $stable(acc_o));

    assert_rail_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && valid_i && acc_o == ACC_MAX && delta > 0) |=> (acc_o == ACC_MAX));

    assert_rail_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && valid_i && acc_o == ACC_MIN && delta < 0) |=> (acc_o == ACC_MIN));

    assert_step_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && valid_i && acc_o == '0) |=>
            (acc_o <= 2 * (1 <<< (SAMP_W-1)) && acc_o >= -2 * (1 <<< (SAMP_W-1))));
endmodule

// File: rtl/xcorr_read_sel.sv
// Module: xcorr_read_sel
// Combinational indexed read of the flattened accumulator matrix.
// Assumes row-major packing: entry (r,c) at index r*CHIPS+c.
module xcorr_read_sel #(
    parameter int ROWS   = 8,
    parameter int CHIPS  = 8,
    parameter int ACC_W  = xcorr_pkg::ACC_W,
    parameter int ROW_IW = (ROWS > 1) ? $clog2(ROWS) : 1,
    parameter int COL_IW = (CHIPS > 1) ? $clog2(CHIPS) : 1
) (
    input  logic [ROWS*CHIPS*ACC_W-1:0] mat_i,
    input  logic [ROW_IW-1:0]           row_i,
    input  logic [COL_IW-1:0]           col_i,
    output logic [ACC_W-1:0]            data_o
);
    // Pick the addressed entry; out-of-range indices read zero.
    always_comb begin
        data_o = '0;
        if (int'(row_i) < ROWS && int'(col_i) < CHIPS) begin
            data_o = mat_i[(int'(row_i) * CHIPS + int'(col_i)) * ACC_W +: ACC_W];
        end
    end

    always_comb begin
        if (int'(row_i) >= ROWS || int'(col_i) >= CHIPS) begin
            assert_oob_zero_R9: assert (data_o == '0);
        end
    end
endmodule

// File: rtl/sliding_xcorr.sv
// Module: sliding_xcorr (top)
// Matrix of ROWS x CHIPS signed accumulators correlating antipodal
// training bits with received samples over a sliding window; entering
// and leaving contributions are applied in one update per bit period.
// Assumes the caller supplies the leaving bits/samples from its window.
module sliding_xcorr #(
    parameter int ROWS   = 8,
    parameter int CHIPS  = 8,
    parameter int SAMP_W = xcorr_pkg::SAMP_W,
    parameter int ACC_W  = xcorr_pkg::ACC_W,
    localparam int ROW_IW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_IW = (CHIPS > 1) ? $clog2(CHIPS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    valid_i,
    input  logic [ROWS-1:0]         new_bits_i,
    input  logic [ROWS-1:0]         old_bits_i,
    input  logic [CHIPS*SAMP_W-1:0] new_samp_i,
    input  logic [CHIPS*SAMP_W-1:0] old_samp_i,
    input  logic [ROW_IW-1:0]       rd_row_i,
    input  logic [COL_IW-1:0]       rd_col_i,
    output logic [ACC_W-1:0]        rd_data_o
);
    localparam int CELLS = ROWS * CHIPS;

    logic [CELLS*ACC_W-1:0] mat_flat;

    // One accumulator per (row, chip) pair.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < CHIPS; c++) begin : g_col
            logic signed [ACC_W-1:0] acc_val;

            xcorr_cell #(.SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_cell (
                .clk        (clk),
                .rst_n      (rst_n),
                .clr_i      (clr_i),
                .valid_i    (valid_i),
                .new_bit_i  (new_bits_i[r]),
                .old_bit_i  (old_bits_i[r]),
                .new_samp_i (new_samp_i[c*SAMP_W +: SAMP_W]),
                .old_samp_i (old_samp_i[c*SAMP_W +: SAMP_W]),
                .acc_o      (acc_val)
            );

            assign mat_flat[(r*CHIPS + c)*ACC_W +: ACC_W] = acc_val;
        end
    end

    xcorr_read_sel #(
        .ROWS(ROWS), .CHIPS(CHIPS), .ACC_W(ACC_W),
        .ROW_IW(ROW_IW), .COL_IW(COL_IW)
    ) u_read (
        .mat_i  (mat_flat),
        .row_i  (rd_row_i),
        .col_i  (rd_col_i),
        .data_o (rd_data_o)
    );

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (mat_flat == '0));
endmodule

// File: tb/tb_sliding_xcorr.sv
`timescale 1ns/1ps
module tb_sliding_xcorr;
    localparam int ROWS  = 8;
    localparam int CHIPS = 8;
    localparam int SW    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic valid = 1'b0;
    logic [ROWS-1:0] nb = '0, ob = '0;
    logic [CHIPS*SW-1:0] ns = '0, os = '0;
    logic [2:0] rrow = '0, rcol = '0;
    logic [15:0] rdata;

    int model [ROWS][CHIPS];
    int n_cmp = 0, n_bad = 0, cycles = 0;

    sliding_xcorr #(.ROWS(ROWS), .CHIPS(CHIPS)) dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .valid_i(valid),
        .new_bits_i(nb), .old_bits_i(ob), .new_samp_i(ns), .old_samp_i(os),
        .rd_row_i(rrow), .rd_col_i(rcol), .rd_data_o(rdata)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still summarises.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check_all(input string tag);
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < CHIPS; c++) begin
                rrow = 3'(r);
                rcol = 3'(c);
                #0.01;
                n_cmp++;
                if ($signed(rdata) != model[r][c]) begin
                    n_bad++;
                    $display("FAIL %s entry(%0d,%0d): actual %0d expected %0d",
                             tag, r, c, $signed(rdata), model[r][c]);
                end
            end
        end
    endtask

    // Model update for one accepted slide, with clamping.
    task automatic model_step();
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < CHIPS; c++) begin
                int a = model[r][c];
                int s_in = $signed(ns[c*SW +: SW]);
                int s_out = $signed(os[c*SW +: SW]);
                a += nb[r] ? s_in : -s_in;
                a += ob[r] ? -s_out : s_out;
                if (a > 32767) a = 32767;
                if (a < -32768) a = -32768;
                model[r][c] = a;
            end
        end
    endtask

    task automatic cycle(input bit v, input bit c, input string tag);
        @(negedge clk);
        valid = v;
        clr = c;
        @(posedge clk);
        #1;
        if (c) begin
            foreach (model[i, j]) model[i][j] = 0;
        end else if (v) begin
            model_step();
        end
        valid = 1'b0;
        clr = 1'b0;
        check_all(tag);
    endtask

    task automatic rand_inputs(input bit new_on, input bit old_on);
        nb = ROWS'($urandom);
        ob = ROWS'($urandom);
        for (int c = 0; c < CHIPS; c++) begin
            ns[c*SW +: SW] = new_on ? SW'($urandom) : '0;
            os[c*SW +: SW] = old_on ? SW'($urandom) : '0;
        end
    endtask

    task automatic fill(input logic [ROWS-1:0] b_in, input logic [ROWS-1:0] b_out,
                        input logic [SW-1:0] s_in, input logic [SW-1:0] s_out);
        nb = b_in;
        ob = b_out;
        for (int c = 0; c < CHIPS; c++) begin
            ns[c*SW +: SW] = s_in;
            os[c*SW +: SW] = s_out;
        end
    endtask

    initial begin
        foreach (model[i, j]) model[i][j] = 0;
        rand_inputs(1'b1, 1'b1);
        valid = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        valid = 1'b0;
        check_all("R1 reset");

        // R4: entering term only (leaving samples zero)
        for (int k = 0; k < 20; k++) begin rand_inputs(1'b1, 1'b0); cycle(1'b1, 1'b0, "R4"); end
        // R5: leaving term only (entering samples zero)
        for (int k = 0; k < 20; k++) begin rand_inputs(1'b0, 1'b1); cycle(1'b1, 1'b0, "R5"); end
        // R6 / R9: both terms, random, full matrix read back
        for (int k = 0; k < 60; k++) begin rand_inputs(1'b1, 1'b1); cycle(1'b1, 1'b0, "R6 R9"); end
        // R3: idle cycles with toggling data
        for (int k = 0; k < 10; k++) begin rand_inputs(1'b1, 1'b1); cycle(1'b0, 1'b0, "R3"); end
        // R2: clear together with valid
        rand_inputs(1'b1, 1'b1);
        cycle(1'b1, 1'b1, "R2");
        // R7: drive to the positive rail (+254 per slide)
        fill('1, '0, 8'sd127, 8'sd127);
        for (int k = 0; k < 140; k++) cycle(1'b1, 1'b0, "R7");
        // R8: drive to the negative rail (-254 per slide)
        fill('0, '1, 8'sd127, 8'sd127);
        for (int k = 0; k < 270; k++) cycle(1'b1, 1'b0, "R8");
        // R6: mixed traffic leaving the rail
        for (int k = 0; k < 40; k++) begin rand_inputs(1'b1, 1'b1); cycle(1'b1, 1'b0, "R6"); end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule